// File: doc/BRIEF.md
# Parity-in-Word Serial Transceiver

This block is an asynchronous serial transmitter and receiver pair that share one baud generator. A single control bit selects a word of 8 or 9 bits. When parity is switched on, the parity bit does not add a position to the frame. It takes the top position of the configured word. An 8-bit word then carries 7 data bits, and a 9-bit word carries 8 data bits. Each frame is a low start bit, the word sent least significant bit first, and one or two high stop bits. Between frames the line rests high.

Characters enter through a valid/ready write port that feeds a one-entry holding register. `tx_ready` is the transmit-empty flag. A producer keeps `tx_valid` and `tx_data` steady until it sees `tx_ready` high at a clock edge. `tx_ready` drops for the cycle in which the holding register passes its character to the shift register, then rises again. The receive side cannot apply back-pressure. `rx_valid` is a one-cycle pulse and must be taken in that cycle. `rx_par_err` and `rx_frm_err` are valid in the same cycle as the data.

The bit period is 16 ticks of an oversampling tick. A tick occurs every `cfg_div` clocks, and a value of 0 behaves as 1. The divisor and the word length are copied into internal registers only while both directions are idle. Parity enable, parity sense and stop count are captured per character.

Top module: `uart_pw`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 1 and `rx_valid` is 0.
- R2: A transmitted frame is one 0 start bit, then the word least significant bit first, then the stop bits at 1. The word has 8 bits when `cfg_nine`=0 and 9 bits when `cfg_nine`=1.
- R3: With `cfg_par_en`=1, the word's top bit (bit 7 in 8-bit mode, bit 8 in 9-bit mode) is the parity of the bits below it. With `cfg_par_odd`=0 the total count of ones is even, and with `cfg_par_odd`=1 it is odd. The top bit of `tx_data` is ignored in that case.
- R4: `cfg_two_stop`=1 sends two stop bits and `cfg_two_stop`=0 sends one. A queued character starts only after the last stop bit.
- R5: The receiver presents the recovered word on `rx_data` with a one-cycle `rx_valid` pulse. When parity was enabled for that character, the parity position and every bit above the word are 0.
- R6: `rx_par_err` is 1 exactly when parity was enabled for the character and the received top bit disagrees with the parity recomputed from the received data bits.
- R7: `rx_frm_err` is 1 when a stop bit is sampled low. The receiver then waits for the line to go high and takes the next falling edge as a new start.
- R8: A change to `cfg_par_en` during a character does not affect that character, in either direction. It applies from the next character.
- R9: An accepted write makes `tx_ready` 0 until the holding register has moved into the shift register. While a frame is in flight and a second character is held, `tx_ready` stays 0.
- R10: Changes to `cfg_div` and `cfg_nine` while either direction is busy do not affect the current frames.
- R11: One bit lasts 16 × `cfg_div` clock cycles, and the receiver samples each bit at its centre.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | DIV_W | Clocks per oversampling tick |
| cfg_nine | input | 1 | Word length: 0 = 8 bits, 1 = 9 bits |
| cfg_par_en | input | 1 | Parity takes the word's top bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| tx_valid | input | 1 | Write request |
| tx_ready | output | 1 | Holding register empty |
| tx_data | input | 9 | Character to send |
| rx_valid | output | 1 | One-cycle receive pulse |
| rx_data | output | 9 | Received word, parity position cleared |
| rx_par_err | output | 1 | Parity mismatch for this character |
| rx_frm_err | output | 1 | Low stop bit for this character |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |

## Verification
A corrupted shift register or bit counter shows on `txd` within the same frame. The symptom is a wrong bit at some bit centre, or a stop bit that runs short into the next start. A receiver whose sub-bit counter or bit index has slipped delivers a shifted word or a false framing error at the end of that character. A per-character capture that fails to hold shows as a changed parity bit or word length in the frame that was in flight when the configuration moved. A holding register that empties or fills at the wrong time shows on `tx_ready` within one or two cycles of the write, or as a lost or duplicated frame.

// File: rtl/uart_pw_pkg.sv
package uart_pw_pkg;
  localparam int OVS       = 16;
  localparam int FRAME_MAX = 12;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_t;

  // word with the parity folded into its top position
  function automatic logic [8:0] pw_encode(input logic [8:0] d, input logic nine,
                                           input logic par_en, input logic odd);
    logic [8:0] w;
    w = nine ? d : {1'b0, d[7:0]};
    if (par_en) begin
      if (nine) w[8] = (^w[7:0]) ^ odd;
      else      w[7] = (^w[6:0]) ^ odd;
    end
    return w;
  endfunction
endpackage

// File: rtl/uart_pw_baud.sv
module uart_pw_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = ({1'b0, cnt} + {{DIV_W{1'b0}}, 1'b1}) >= {1'b0, div};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= wrap;
      cnt  <= wrap ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_pw_tx.sv
module uart_pw_tx
  import uart_pw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       nine,
  input  logic       two_stop,
  input  logic       par_en,
  input  logic       odd,
  input  logic       ld_valid,
  input  logic [8:0] ld_data,
  output logic       ld_take,
  output logic       busy,
  output logic       txd
);
  localparam int SUB_W = $clog2(OVS);
  localparam int CNT_W = $clog2(FRAME_MAX + 1);

  logic [FRAME_MAX-1:0] shift;
  logic [CNT_W-1:0]     bits_left;
  logic [SUB_W-1:0]     sub;
  logic [8:0]           w;

  assign busy    = bits_left != '0;
  assign ld_take = ld_valid && !busy;
  assign txd     = shift[0];
  assign w       = pw_encode(ld_data, nine, par_en, odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift     <= '1;
      bits_left <= '0;
      sub       <= '0;
    end else if (ld_take) begin
      sub <= '0;
      if (nine) begin
        shift     <= {2'b11, w, 1'b0};
        bits_left <= two_stop ? CNT_W'(12) : CNT_W'(11);
      end else begin
        shift     <= {3'b111, w[7:0], 1'b0};
        bits_left <= two_stop ? CNT_W'(11) : CNT_W'(10);
      end
    end else if (tick && busy) begin
      if (sub == SUB_W'(OVS - 1)) begin
        sub       <= '0;
        shift     <= {1'b1, shift[FRAME_MAX-1:1]};
        bits_left <= bits_left - 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  // R2: a frame always opens with a low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
endmodule

// File: rtl/uart_pw_rx.sv
module uart_pw_rx
  import uart_pw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       nine,
  input  logic       two_stop,
  input  logic       par_en,
  input  logic       odd,
  output logic       busy,
  output logic       out_valid,
  output logic [8:0] out_data,
  output logic       out_perr,
  output logic       out_ferr
);
  localparam int SUB_W = $clog2(OVS);

  rx_state_t        st;
  logic [SUB_W-1:0] sub;
  logic [3:0]       idx;
  logic [8:0]       word;
  logic             s1, s2, prev;
  logic             par_c, odd_c, two_c, stop2, ferr;
  logic [8:0]       masked;
  logic             pbits;

  assign busy = st != RX_IDLE;

  always_comb begin
    unique case ({nine, par_c})
      2'b00:   masked = {1'b0, word[7:0]};
      2'b01:   masked = {2'b00, word[6:0]};
      2'b10:   masked = word;
      default: masked = {1'b0, word[7:0]};
    endcase
    pbits = nine ? ^word : ^word[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; sub <= '0; idx <= '0; word <= '0;
      s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1;
      par_c <= 1'b0; odd_c <= 1'b0; two_c <= 1'b0; stop2 <= 1'b0; ferr <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; out_perr <= 1'b0; out_ferr <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      s1 <= rxd;
      s2 <= s1;
      if (tick) begin
        prev <= s2;
        unique case (st)
          RX_IDLE: if (prev && !s2) begin
            st <= RX_START; sub <= '0;
            par_c <= par_en; odd_c <= odd; two_c <= two_stop;
          end
          RX_START: if (sub == SUB_W'(OVS/2 - 1)) begin
            sub <= '0; idx <= '0;
            st  <= s2 ? RX_IDLE : RX_BITS;
          end else sub <= sub + 1'b1;
          RX_BITS: if (sub == SUB_W'(OVS - 1)) begin
            sub <= '0;
            word[idx] <= s2;
            idx <= idx + 1'b1;
            if (idx == (nine ? 4'd8 : 4'd7)) begin
              st <= RX_STOP; stop2 <= two_c; ferr <= 1'b0;
            end
          end else sub <= sub + 1'b1;
          RX_STOP: if (sub == SUB_W'(OVS - 1)) begin
            sub <= '0;
            if (stop2) begin
              stop2 <= 1'b0;
              ferr  <= !s2;
            end else begin
              st        <= RX_IDLE;
              out_valid <= 1'b1;
              out_data  <= masked;
              out_perr  <= par_c && (pbits != odd_c);
              out_ferr  <= ferr || !s2;
            end
          end else sub <= sub + 1'b1;
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  // R5: delivery is a single-cycle pulse
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R5: parity position cleared in 8-bit mode
  p_par_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && par_c && !nine |-> out_data[8:7] == 2'b00);
endmodule

// File: rtl/uart_pw.sv
module uart_pw
  import uart_pw_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_nine,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_two_stop,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [8:0]       tx_data,
  output logic             rx_valid,
  output logic [8:0]       rx_data,
  output logic             rx_par_err,
  output logic             rx_frm_err,
  output logic             txd,
  input  logic             rxd
);
  logic [DIV_W-1:0] act_div;
  logic             act_nine;
  logic             tick, tx_busy, rx_busy, ld_take;
  logic             hold_full;
  logic [8:0]       hold_data;

  assign tx_ready = !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div   <= DIV_W'(1);
      act_nine  <= 1'b0;
      hold_full <= 1'b0;
      hold_data <= '0;
    end else begin
      if (!tx_busy && !rx_busy) begin
        act_div  <= cfg_div;
        act_nine <= cfg_nine;
      end
      if (tx_valid && tx_ready) begin
        hold_full <= 1'b1;
        hold_data <= tx_data;
      end else if (ld_take) begin
        hold_full <= 1'b0;
      end
    end
  end

  uart_pw_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(act_div), .tick(tick));

  uart_pw_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .nine(act_nine),
    .two_stop(cfg_two_stop), .par_en(cfg_par_en), .odd(cfg_par_odd),
    .ld_valid(hold_full), .ld_data(hold_data), .ld_take(ld_take),
    .busy(tx_busy), .txd(txd));

  uart_pw_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .nine(act_nine),
    .two_stop(cfg_two_stop), .par_en(cfg_par_en), .odd(cfg_par_odd),
    .busy(rx_busy), .out_valid(rx_valid), .out_data(rx_data),
    .out_perr(rx_par_err), .out_ferr(rx_frm_err));

  // R9: an accepted write fills the holding register for at least a cycle
  p_hold_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);
  // R10: timing and length settings frozen while a frame is active
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy || rx_busy) |=> $stable(act_nine) && $stable(act_div));
endmodule

// File: tb/tb_uart_pw.sv
`timescale 1ns/1ps
module tb_uart_pw;
  localparam int DIV    = 2;
  localparam int BIT_NS = 16 * DIV * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cfg_div = 16'(DIV);
  logic cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic tx_valid = 1'b0;
  logic [8:0] tx_data = '0;
  logic tx_ready, rx_valid, rx_par_err, rx_frm_err, txd, rxd;
  logic [8:0] rx_data;
  logic loop_en = 1'b1, rxd_tb = 1'b1;
  int n_chk = 0, n_err = 0, rx_cnt = 0;
  logic [8:0] r_data;
  logic r_perr, r_ferr;

  always #2 clk = ~clk;
  assign rxd = loop_en ? txd : rxd_tb;

  uart_pw dut (.clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_nine(cfg_nine),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
    .txd(txd), .rxd(rxd));

  always @(negedge clk) if (rx_valid) begin
    rx_cnt++; r_data = rx_data; r_perr = rx_par_err; r_ferr = rx_frm_err;
  end

  // {nine, par_en, odd, two_stop, data[8:0]}
  localparam logic [12:0] VEC [6] = '{
    {4'b0000, 9'h0A5}, {4'b1000, 9'h15A}, {4'b0100, 9'h0FF},
    {4'b0110, 9'h0FF}, {4'b1111, 9'h0C3}, {4'b1101, 9'h1FE}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_word(input logic nine, par, odd, input logic [8:0] d);
    int n = nine ? 9 : 8;
    int ones = 0;
    logic [8:0] w = '0;
    for (int i = 0; i < n - (par ? 1 : 0); i++) begin
      w[i] = d[i]; ones += int'(d[i]);
    end
    if (par) w[n-1] = logic'(ones % 2) ^ odd;
    return w;
  endfunction

  function automatic logic [8:0] exp_rx(input logic nine, par, input logic [8:0] w);
    logic [8:0] r = nine ? w : {1'b0, w[7:0]};
    if (par) r[nine ? 8 : 7] = 1'b0;
    return r;
  endfunction

  function automatic logic [11:0] exp_frame(input logic nine, input logic [8:0] w);
    logic [11:0] f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < (nine ? 9 : 8); i++) f[i+1] = w[i];
    return f;
  endfunction

  task automatic tx_write(input logic [8:0] d);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic get_frame(input int n, output logic [11:0] f);
    f = '1;
    @(negedge txd);
    #(BIT_NS/2 + 2);
    for (int i = 0; i < n; i++) begin
      f[i] = txd;
      if (i < n - 1) #(BIT_NS);
    end
  endtask

  task automatic wait_rx(input int prev);
    int t = 0;
    while (rx_cnt == prev && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic send_raw(input logic [11:0] f, input int n);
    for (int i = 0; i < n; i++) begin rxd_tb = f[i]; #(BIT_NS); end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  initial begin
    #600000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [11:0] f, g, m;
    logic [8:0] w;
    int len, c;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(txd == 1'b1, "R1 txd", int'(txd), 1);
    chk(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);
    chk(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R3 R5 R11: table walk in loopback
    foreach (VEC[k]) begin
      {cfg_nine, cfg_par_en, cfg_par_odd, cfg_two_stop} = VEC[k][12:9];
      repeat (4) @(negedge clk);
      w   = exp_word(cfg_nine, cfg_par_en, cfg_par_odd, VEC[k][8:0]);
      len = 1 + (cfg_nine ? 9 : 8) + (cfg_two_stop ? 2 : 1);
      m   = 12'((1 << len) - 1);
      c   = rx_cnt;
      tx_write(VEC[k][8:0]);
      get_frame(len, f);
      chk((f & m) == (exp_frame(cfg_nine, w) & m), "R2/R3 frame", int'(f & m),
          int'(exp_frame(cfg_nine, w) & m));
      wait_rx(c);
      chk(r_data == exp_rx(cfg_nine, cfg_par_en, w) && !r_perr && !r_ferr, "R5 rx word",
          int'({r_perr, r_ferr, r_data}), int'(exp_rx(cfg_nine, cfg_par_en, w)));
      #(BIT_NS * 3);
    end

    // R9: holding register empties right after a lone write
    cfg_nine = 0; cfg_par_en = 0; cfg_two_stop = 1;
    repeat (4) @(negedge clk);
    tx_write(9'h033);
    repeat (2) @(negedge clk);
    chk(tx_ready == 1'b1, "R9 ready after move", int'(tx_ready), 1);
    #(BIT_NS * 14);

    // R4 R9: back-to-back with two stop bits
    c = rx_cnt;
    fork
      begin tx_write(9'h033); tx_write(9'h0C6); end
    join_none
    get_frame(11, f);
    chk(tx_ready == 1'b0, "R9 ready held low", int'(tx_ready), 0);
    get_frame(11, g);
    chk(f[10:0] == exp_frame(0, 9'h033)[10:0], "R4 first frame", int'(f[10:0]),
        int'(exp_frame(0, 9'h033)[10:0]));
    chk(g[10:0] == exp_frame(0, 9'h0C6)[10:0], "R4 second frame", int'(g[10:0]),
        int'(exp_frame(0, 9'h0C6)[10:0]));
    wait_rx(c + 1);
    chk(rx_cnt == c + 2 && r_data == 9'h0C6, "R4 both received", int'(r_data), 'hC6);
    #(BIT_NS * 3);

    // R8 R10: config moved mid-frame
    cfg_two_stop = 0; cfg_par_en = 1; cfg_par_odd = 0; cfg_nine = 0;
    repeat (4) @(negedge clk);
    c = rx_cnt;
    tx_write(9'h007);
    fork
      begin #(BIT_NS * 3); cfg_par_en = 0; cfg_nine = 1; cfg_div = 16'd5; end
    join_none
    get_frame(10, f);
    chk(f[9:0] == exp_frame(0, 9'h087)[9:0], "R8/R10 tx frame", int'(f[9:0]),
        int'(exp_frame(0, 9'h087)[9:0]));
    wait_rx(c);
    chk(r_data == 9'h007 && !r_perr, "R8 rx in flight", int'({r_perr, r_data}), 'h007);
    cfg_nine = 0; cfg_div = 16'(DIV);
    #(BIT_NS * 3);
    // R8: new parity setting used by the next character
    c = rx_cnt;
    tx_write(9'h087);
    get_frame(10, f);
    chk(f[9:0] == exp_frame(0, 9'h087)[9:0], "R8 next frame", int'(f[9:0]),
        int'(exp_frame(0, 9'h087)[9:0]));
    wait_rx(c);
    chk(r_data == 9'h087 && !r_perr, "R8 next rx", int'({r_perr, r_data}), 'h087);
    #(BIT_NS * 3);

    // R6 R7: raw receive
    loop_en = 0; rxd_tb = 1;
    cfg_par_en = 1; cfg_par_odd = 0;
    #(BIT_NS * 2);
    c = rx_cnt;
    send_raw({2'b11, 1'b1, 8'h07, 1'b0}, 10);
    wait_rx(c);
    chk(r_perr == 1'b1 && r_data == 9'h007 && !r_ferr, "R6 bad parity",
        int'({r_perr, r_data}), 'h207);
    c = rx_cnt;
    send_raw({2'b11, 1'b1, 8'h87, 1'b0}, 10);
    wait_rx(c);
    chk(r_perr == 1'b0 && r_data == 9'h007, "R6 good parity", int'({r_perr, r_data}), 'h007);
    cfg_par_en = 0;
    #(BIT_NS);
    c = rx_cnt;
    send_raw({2'b11, 1'b0, 8'h55, 1'b0}, 10);
    rxd_tb = 0;
    wait_rx(c);
    chk(r_ferr == 1'b1 && r_data == 9'h055, "R7 framing error", int'({r_ferr, r_data}), 'h255);
    #(BIT_NS * 2);
    rxd_tb = 1;
    #(BIT_NS);
    chk(rx_cnt == c + 1, "R7 no spurious char", rx_cnt, c + 1);
    c = rx_cnt;
    send_raw({2'b11, 1'b1, 8'h3C, 1'b0}, 10);
    rxd_tb = 1;
    wait_rx(c);
    chk(r_ferr == 1'b0 && r_data == 9'h03C, "R7 resync", int'({r_ferr, r_data}), 'h03C);

    summary();
    $finish;
  end
endmodule